// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between the load/store stage of a processor core and a byte-addressed data memory port. For each access it receives a base register value, a 12-bit immediate, a width code, a load/store select and an unsigned flag. It forms the effective address and checks that the address is naturally aligned for the width. A configuration input lets misaligned addresses through instead of faulting. The unit also rejects width and flag combinations that are not legal encodings.

A legal access becomes one registered request on the memory port. For a store, the unit builds byte enables from the width and the low address bits and rotates the low width bytes of the source operand onto the matching byte lanes. When the memory response returns, a load has its bytes gathered back from those lanes and is zero- or sign-extended to register width. The unit then produces a register write-back. An error response becomes an access-fault exception, and no write-back is made.

The unit keeps one access outstanding. The core presents a new request only after the previous one has completed, and a request never arrives in the same cycle as a memory response.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `req_base` plus the sign-extended `req_imm`, modulo 2^XLEN. It appears on `mem_addr` for an issued access and on `exc_addr` for a misaligned or illegal access.
- R2: Width codes are 0 = byte, 1 = halfword, 2 = word, 3 = doubleword, and an access of 2^w bytes is aligned when its low w address bits are zero. A misaligned access while `cfg_misaligned_ok` is 0 raises an exception and issues no memory request. While `cfg_misaligned_ok` is 1, the same access is issued unchanged.
- R3: Exception cause codes are 4 = load misaligned, 5 = load access fault, 6 = store misaligned, 7 = store access fault and 2 = illegal access.
- R4: Load results are zero-extended when `req_unsigned` is 1 and sign-extended from the top loaded bit when it is 0.
- R5: A store asserts byte enable (A+i) mod NB for i below the access size, where A is the effective address and NB = XLEN/8. That lane carries byte i of `req_src`, and every lane that is not enabled carries zero.
- R6: A response with `mem_err` = 1 raises an access fault with the access's effective address on `exc_addr`, and `wb_valid` stays 0.
- R7: A doubleword access when XLEN is 32, or an unsigned load whose width equals the register width, raises the illegal cause and issues no memory request. The illegal check takes priority over the misaligned check.
- R8: `mem_req`, or the exception for a rejected access, appears in the cycle after `req_valid`. The write-back or fault appears in the cycle after `mem_rvalid`. `op_done` pulses for one cycle with every completion.
- R9: Byte i of a load result comes from byte lane (A+i) mod NB of `mem_rdata`, and `wb_rd` carries the destination index of the access.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_misaligned_ok | input | 1 | 1 lets misaligned accesses through to memory |
| req_valid | input | 1 | Access request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_unsigned | input | 1 | Zero-extend the load result |
| req_width | input | 2 | Access width code |
| req_base | input | XLEN | Base register value |
| req_imm | input | 12 | Signed immediate offset |
| req_src | input | XLEN | Store source register value |
| req_rd | input | 5 | Load destination register index |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | XLEN | Effective byte address |
| mem_be | output | XLEN/8 | Byte-lane enables |
| mem_wdata | output | XLEN | Lane-aligned store data |
| mem_rvalid | input | 1 | Memory response strobe |
| mem_rdata | input | XLEN | Memory read data, by lane |
| mem_err | input | 1 | Memory error response |
| wb_valid | output | 1 | Register write-back strobe |
| wb_rd | output | 5 | Write-back register index |
| wb_data | output | XLEN | Extended load result |
| exc_valid | output | 1 | Exception strobe |
| exc_cause | output | 3 | Exception cause code |
| exc_addr | output | XLEN | Faulting effective address |
| op_done | output | 1 | Access completion pulse |

## Verification
The bench targets the cases where a design would deliver the wrong value without any visible breakdown. It loads a byte whose top bit is set, once signed and once unsigned, which catches a mix-up of the two extension kinds. It uses a negative immediate, which exposes a zero-extended offset as an address 4 KiB too high. It runs a misaligned word load with the enable low, which must fault without a memory request, and again with the enable high, which must return the wrapped lanes. A store of a byte into the top lane and a doubleword store at lane offset 3 show whether the byte enables or the store data are shifted instead of rotated, or whether unwanted source bytes leak onto the bus. Error responses on a load and on a store must raise the fault cause for that direction and suppress the write-back. An unsigned full-width load must be rejected as illegal before it reaches the alignment check.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_ILLEGAL   = 3'd2,
    CAUSE_LD_MISAL  = 3'd4,
    CAUSE_LD_FAULT  = 3'd5,
    CAUSE_ST_MISAL  = 3'd6,
    CAUSE_ST_FAULT  = 3'd7
  } cause_e;

  localparam int IMM_W = 12;
  localparam int RD_W  = 5;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int XLEN = 64,
  localparam int NB = XLEN / 8,
  localparam int OFFW = $clog2(NB)
) (
  input  logic [XLEN-1:0]          base,
  input  logic [lsu_pkg::IMM_W-1:0] imm,
  input  logic [1:0]               width,
  input  logic                     is_store,
  input  logic                     is_unsigned,
  input  logic                     misal_ok,
  output logic [XLEN-1:0]          eff_addr,
  output logic                     illegal,
  output logic                     misal_fault
);
  logic [OFFW:0]   amask;
  logic [OFFW-1:0] low_bits;

  always_comb begin
    eff_addr = base + {{(XLEN-lsu_pkg::IMM_W){imm[lsu_pkg::IMM_W-1]}}, imm};
    amask    = ~({(OFFW+1){1'b1}} << width);
    low_bits = eff_addr[OFFW-1:0] & amask[OFFW-1:0];
    illegal  = (32'(width) > OFFW) ||
               (!is_store && is_unsigned && (32'(width) == OFFW));
    misal_fault = !misal_ok && (low_bits != '0);
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
  parameter int XLEN = 64,
  localparam int NB = XLEN / 8,
  localparam int OFFW = $clog2(NB),
  localparam int SHW = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] src,
  input  logic [1:0]      width,
  input  logic [OFFW-1:0] off,
  output logic [NB-1:0]   be,
  output logic [XLEN-1:0] lane_data
);
  logic [SHW-1:0]  nbits;
  logic [SHW-1:0]  sh;
  logic [OFFW:0]   nbytes;
  logic [NB-1:0]   bmask;
  logic [XLEN-1:0] masked;

  always_comb begin
    nbits     = SHW'(8) << width;
    nbytes    = (OFFW+1)'(1) << width;
    sh        = {off, 3'b000};
    masked    = src & ~({XLEN{1'b1}} << nbits);
    bmask     = ~({NB{1'b1}} << nbytes);
    be        = (bmask << off) | (bmask >> ((OFFW+1)'(NB) - {1'b0, off}));
    lane_data = (masked << sh) | (masked >> (SHW'(XLEN) - sh));
  end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend #(
  parameter int XLEN = 64,
  localparam int NB = XLEN / 8,
  localparam int OFFW = $clog2(NB),
  localparam int SHW = $clog2(XLEN) + 1,
  localparam int IW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] rdata,
  input  logic [1:0]      width,
  input  logic [OFFW-1:0] off,
  input  logic            is_unsigned,
  output logic [XLEN-1:0] result
);
  logic [SHW-1:0]  nbits;
  logic [SHW-1:0]  sh;
  logic [XLEN-1:0] gathered;
  logic [XLEN-1:0] lowmask;
  logic [IW-1:0]   top_idx;
  logic            sign;

  always_comb begin
    nbits    = SHW'(8) << width;
    sh       = {off, 3'b000};
    gathered = (rdata >> sh) | (rdata << (SHW'(XLEN) - sh));
    lowmask  = ~({XLEN{1'b1}} << nbits);
    top_idx  = IW'(nbits - SHW'(1));
    sign     = !is_unsigned && gathered[top_idx];
    result   = (gathered & lowmask) | ({XLEN{sign}} & ~lowmask);
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit #(
  parameter int XLEN = 64,
  localparam int NB = XLEN / 8,
  localparam int OFFW = $clog2(NB)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_misaligned_ok,
  input  logic                      req_valid,
  input  logic                      req_store,
  input  logic                      req_unsigned,
  input  logic [1:0]                req_width,
  input  logic [XLEN-1:0]           req_base,
  input  logic [lsu_pkg::IMM_W-1:0] req_imm,
  input  logic [XLEN-1:0]           req_src,
  input  logic [lsu_pkg::RD_W-1:0]  req_rd,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [XLEN-1:0]           mem_addr,
  output logic [NB-1:0]             mem_be,
  output logic [XLEN-1:0]           mem_wdata,
  input  logic                      mem_rvalid,
  input  logic [XLEN-1:0]           mem_rdata,
  input  logic                      mem_err,
  output logic                      wb_valid,
  output logic [lsu_pkg::RD_W-1:0]  wb_rd,
  output logic [XLEN-1:0]           wb_data,
  output logic                      exc_valid,
  output logic [2:0]                exc_cause,
  output logic [XLEN-1:0]           exc_addr,
  output logic                      op_done
);
  import lsu_pkg::*;

  logic [XLEN-1:0] eff_addr;
  logic            illegal, misal_fault;
  logic [NB-1:0]   st_be;
  logic [XLEN-1:0] st_data;
  logic [XLEN-1:0] ld_result;

  // context of the one outstanding access
  logic             p_store, p_unsigned;
  logic [1:0]       p_width;
  logic [RD_W-1:0]  p_rd;

  lsu_agen #(.XLEN(XLEN)) u_agen (
    .base(req_base), .imm(req_imm), .width(req_width),
    .is_store(req_store), .is_unsigned(req_unsigned),
    .misal_ok(cfg_misaligned_ok), .eff_addr(eff_addr),
    .illegal(illegal), .misal_fault(misal_fault)
  );

  lsu_store_lanes #(.XLEN(XLEN)) u_st (
    .src(req_src), .width(req_width), .off(eff_addr[OFFW-1:0]),
    .be(st_be), .lane_data(st_data)
  );

  lsu_load_extend #(.XLEN(XLEN)) u_ld (
    .rdata(mem_rdata), .width(p_width), .off(mem_addr[OFFW-1:0]),
    .is_unsigned(p_unsigned), .result(ld_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      wb_valid   <= 1'b0;
      wb_rd      <= '0;
      wb_data    <= '0;
      exc_valid  <= 1'b0;
      exc_cause  <= CAUSE_NONE;
      exc_addr   <= '0;
      op_done    <= 1'b0;
      p_store    <= 1'b0;
      p_unsigned <= 1'b0;
      p_width    <= '0;
      p_rd       <= '0;
    end else begin
      mem_req   <= 1'b0;
      wb_valid  <= 1'b0;
      exc_valid <= 1'b0;
      op_done   <= 1'b0;
      if (req_valid) begin
        if (illegal || misal_fault) begin
          exc_valid <= 1'b1;
          op_done   <= 1'b1;
          exc_addr  <= eff_addr;
          if (illegal)        exc_cause <= CAUSE_ILLEGAL;
          else if (req_store) exc_cause <= CAUSE_ST_MISAL;
          else                exc_cause <= CAUSE_LD_MISAL;
        end else begin
          mem_req    <= 1'b1;
          mem_we     <= req_store;
          mem_addr   <= eff_addr;
          mem_be     <= req_store ? st_be : '0;
          mem_wdata  <= req_store ? st_data : '0;
          p_store    <= req_store;
          p_unsigned <= req_unsigned;
          p_width    <= req_width;
          p_rd       <= req_rd;
        end
      end
      if (mem_rvalid) begin
        op_done <= 1'b1;
        if (mem_err) begin
          exc_valid <= 1'b1;
          exc_addr  <= mem_addr;
          exc_cause <= p_store ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
        end else if (!p_store) begin
          wb_valid <= 1'b1;
          wb_rd    <= p_rd;
          wb_data  <= ld_result;
        end
      end
    end
  end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int XLEN = 64,
  localparam int NB = XLEN / 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            mem_req,
  input logic            mem_we,
  input logic [NB-1:0]   mem_be,
  input logic [XLEN-1:0] mem_wdata,
  input logic            mem_rvalid,
  input logic            mem_err,
  input logic            wb_valid,
  input logic            exc_valid,
  input logic [2:0]      exc_cause,
  input logic            op_done
);
  logic [XLEN-1:0] be_bits;
  always_comb begin
    for (int i = 0; i < NB; i++) be_bits[8*i +: 8] = {8{mem_be[i]}};
  end

  assert_req_answered_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (mem_req ^ exc_valid));
  assert_single_req_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_resp_done_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |=> op_done);
  assert_exc_done_R8: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> op_done);
  assert_err_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_rvalid && mem_err) |=> (exc_valid && !wb_valid));
  assert_wdata_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_wdata & ~be_bits) == '0 && mem_be != '0 &&
      (($countones(mem_be) & ($countones(mem_be) - 1)) == 0)));
  assert_cause_code_R3: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_cause == 3'd2 || exc_cause[2]));
endmodule

bind lsu_align_unit lsu_align_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .mem_req(mem_req),
  .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .mem_rvalid(mem_rvalid), .mem_err(mem_err), .wb_valid(wb_valid),
  .exc_valid(exc_valid), .exc_cause(exc_cause), .op_done(op_done)
);

// File: tb/test_lsu_align_unit.sv
`timescale 1ns/1ps
module test_lsu_align_unit;
  localparam int XLEN = 64;
  localparam int NB = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_misaligned_ok = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0] req_width = '0;
  logic [63:0] req_base = '0, req_src = '0;
  logic [11:0] req_imm = '0;
  logic [4:0] req_rd = '0;
  logic mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic [7:0] mem_be;
  logic mem_rvalid = 1'b0, mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic wb_valid, exc_valid, op_done;
  logic [4:0] wb_rd;
  logic [63:0] wb_data, exc_addr;
  logic [2:0] exc_cause;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lsu_align_unit #(.XLEN(XLEN)) i_lsu_align_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] eff(input logic [63:0] b, input logic [11:0] im);
    logic [63:0] s = {{52{im[11]}}, im};
    return b + s;
  endfunction

  function automatic logic [63:0] exp_load(input logic [63:0] rd, input int w, input bit uns, input int off);
    logic [63:0] v = '0;
    int nb = 1 << w;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = rd[8*((off+i)%NB) +: 8];
    if (!uns && v[8*nb-1])
      for (int k = 8*nb; k < 64; k++) v[k] = 1'b1;
    return v;
  endfunction

  // drive one request; returns after outputs of the request cycle are settled
  task automatic issue(input bit st, input bit uns, input int w, input logic [63:0] b,
                       input logic [11:0] im, input logic [63:0] src, input logic [4:0] rd,
                       input bit mok);
    @(negedge clk);
    req_valid = 1; req_store = st; req_unsigned = uns; req_width = 2'(w);
    req_base = b; req_imm = im; req_src = src; req_rd = rd; cfg_misaligned_ok = mok;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic respond(input logic [63:0] rd, input bit err);
    mem_rvalid = 1; mem_rdata = rd; mem_err = err;
    @(negedge clk);
    mem_rvalid = 0; mem_err = 0;
  endtask

  task automatic t_load(input string tag, input bit uns, input int w, input logic [63:0] b,
                        input logic [11:0] im, input logic [63:0] rdata, input bit mok);
    logic [63:0] a = eff(b, im);
    logic [63:0] e = exp_load(rdata, w, uns, int'(a[2:0]));
    issue(0, uns, w, b, im, 64'h0, 5'd9, mok);
    chk(mem_req && !mem_we && !exc_valid, {tag, " R8 issue"}, {62'b0, mem_req, exc_valid}, 64'd2);
    chk(mem_addr == a, {tag, " R1 addr"}, mem_addr, a);
    respond(rdata, 0);
    chk(wb_valid && op_done && !exc_valid, {tag, " R8 wb strobe"}, {61'b0, wb_valid, op_done, exc_valid}, 64'd6);
    chk(wb_data == e, {tag, " R4 R9 data"}, wb_data, e);
    chk(wb_rd == 5'd9, {tag, " R9 rd"}, 64'(wb_rd), 64'd9);
  endtask

  task automatic t_store(input string tag, input int w, input logic [63:0] b,
                         input logic [11:0] im, input logic [63:0] src, input bit mok);
    logic [63:0] a = eff(b, im);
    logic [7:0] ebe = '0;
    logic [63:0] ed = '0;
    for (int i = 0; i < (1 << w); i++) begin
      ebe[(int'(a[2:0]) + i) % NB] = 1'b1;
      ed[8*((int'(a[2:0]) + i) % NB) +: 8] = src[8*i +: 8];
    end
    issue(1, 0, w, b, im, src, 5'd0, mok);
    chk(mem_req && mem_we, {tag, " R8 issue"}, {62'b0, mem_req, mem_we}, 64'd3);
    chk(mem_be == ebe, {tag, " R5 be"}, 64'(mem_be), 64'(ebe));
    chk(mem_wdata == ed, {tag, " R5 data"}, mem_wdata, ed);
    respond(64'h0, 0);
    chk(op_done && !wb_valid && !exc_valid, {tag, " R8 done"}, {61'b0, op_done, wb_valid, exc_valid}, 64'd4);
  endtask

  task automatic t_reject(input string tag, input bit st, input bit uns, input int w,
                          input logic [63:0] b, input logic [11:0] im, input bit mok,
                          input logic [2:0] cause);
    logic [63:0] a = eff(b, im);
    issue(st, uns, w, b, im, 64'h0, 5'd3, mok);
    chk(exc_valid && !mem_req && op_done, {tag, " R2 R7 no request"}, {61'b0, exc_valid, mem_req, op_done}, 64'd5);
    chk(exc_cause == cause, {tag, " R3 cause"}, 64'(exc_cause), 64'(cause));
    chk(exc_addr == a, {tag, " R1 exc addr"}, exc_addr, a);
  endtask

  task automatic t_fault(input string tag, input bit st, input logic [63:0] b, input logic [2:0] cause);
    issue(st, 0, 3, b, 12'h0, 64'h1234, 5'd4, 0);
    chk(mem_req, {tag, " R8 issue"}, 64'(mem_req), 64'd1);
    respond(64'hFFFF_FFFF_FFFF_FFFF, 1);
    chk(exc_valid && !wb_valid && op_done, {tag, " R6 fault no wb"}, {61'b0, exc_valid, wb_valid, op_done}, 64'd5);
    chk(exc_cause == cause, {tag, " R3 R6 cause"}, 64'(exc_cause), 64'(cause));
    chk(exc_addr == b, {tag, " R6 addr"}, exc_addr, b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk(!mem_req && !mem_we && mem_addr == 0 && mem_be == 0 && mem_wdata == 0 && !wb_valid &&
        wb_data == 0 && !exc_valid && exc_cause == 0 && exc_addr == 0 && !op_done && wb_rd == 0,
        "R10 reset", {mem_addr[31:0], 32'(mem_be)}, 64'd0);

    t_load("ld byte signed", 0, 0, 64'h1000, 12'h003, 64'h0000_0000_8000_0000, 0);
    t_load("ld byte unsigned", 1, 0, 64'h1000, 12'h003, 64'h0000_0000_8000_0000, 0);
    t_load("ld half neg imm", 0, 1, 64'h1010, 12'hFF6, 64'hC3A5_0000_0000_0000, 0);
    t_load("ld word unsigned", 1, 2, 64'h2004, 12'h000, 64'hF00D_BEEF_1111_2222, 0);
    t_load("ld word signed", 0, 2, 64'h2000, 12'h004, 64'hF00D_BEEF_1111_2222, 0);
    t_load("ld double", 0, 3, 64'h3000, 12'h008, 64'h8877_6655_4433_2211, 0);
    t_reject("ld word misaligned", 0, 0, 2, 64'h4000, 12'h002, 0, 3'd4);
    t_load("ld word misaligned allowed", 0, 2, 64'h4000, 12'h006, 64'h8877_6655_4433_2211, 1);
    t_reject("st half misaligned", 1, 0, 1, 64'h5001, 12'h000, 0, 3'd6);
    t_store("st word", 2, 64'h6000, 12'h004, 64'hAAAA_BBBB_1234_5678, 0);
    t_store("st byte top lane", 0, 64'h6000, 12'h007, 64'hFFFF_FFFF_FFFF_FF5A, 0);
    t_store("st double misaligned allowed", 3, 64'h6003, 12'h000, 64'h0102_0304_0506_0708, 1);
    t_fault("ld fault", 0, 64'h7000, 3'd5);
    t_fault("st fault", 1, 64'h7008, 3'd7);
    t_reject("ld unsigned full width illegal", 0, 1, 3, 64'h8001, 12'h000, 0, 3'd2);
    t_reject("ld unsigned full width illegal prio", 0, 1, 3, 64'h8000, 12'h000, 1, 3'd2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R8 act=%h exp=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule